// File: doc/BRIEF.md
# Sine-Triangle PWM Carrier Generator

This block produces a symmetric triangle carrier from a fixed-point phase accumulator. It compares the carrier with a sine reference to give a sine-triangle PWM gate level. On every clock the carrier moves up or down by one slope step. The slope is the product of the frequency increment and the carrier peak, so the carrier frequency depends only on the increment. For a 40 MHz clock, an increment of 0.0004 gives a 4 kHz carrier and 0.005 gives 50 kHz. The formula is increment = 4 × f_carrier × clock period.

The modulation index does not scale the sine reference. It scales the carrier instead, and the carrier peak is supplied as the precomputed reciprocal of the index. A small peak gives deep modulation. A peak below one lets the sine swing past the carrier, which is overmodulation, and the block accepts it. A sample-clock level goes high at each positive carrier extreme and low at each negative one. Other logic can use its edges to time encoder reads or ADC conversions that line up with the carrier. The carrier is locked to the system clock and has no phase tie to the sine.

Top module: `spwm_carrier_gen`

## Requirements
- R1: The step increment `freq_inc` is unsigned with 24 fractional bits and no integer bits. The carrier peak `peak_lvl` is unsigned Q3.24. The carrier `carrier` and the sine `sine_ref` are signed two's-complement Q4.24. The slope per clock is freq_inc × peak_lvl, and a new setting takes effect one clock after it is presented.
- R2: When a rising carrier would reach or pass +peak, the carrier is set to exactly +peak and starts falling, and `samp_clk` goes high in that same cycle.
- R3: When a falling carrier would reach or pass −peak, the carrier is set to exactly −peak and starts rising, and `samp_clk` goes low in that same cycle.
- R4: When the slope divides the peak evenly, successive rising edges of `samp_clk` are 4/freq_inc clocks apart, whatever the peak is.
- R5: `pwm_out` is high exactly when the sine value at the previous clock edge was strictly greater than the carrier at that edge. A tie gives low.
- R6: A sine magnitude above the peak (overmodulation) is accepted. The carrier stays within ±peak, and `pwm_out` stays fixed at the level of the sine's sign.
- R7: While the synchronous active-high reset `rst` is asserted, the carrier is 0, the ramp direction is upward, and `pwm_out` and `samp_clk` are low. The slope register is also cleared, so the first clock after release leaves the carrier at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_inc | input | 24 | Carrier frequency increment, unsigned Q0.24 |
| peak_lvl | input | 27 | Carrier peak (1/modulation index), unsigned Q3.24 |
| sine_ref | input | 28 | Sine reference, signed Q4.24 |
| carrier | output | 28 | Triangle carrier sample, signed Q4.24 |
| pwm_out | output | 1 | Registered PWM gate level |
| samp_clk | output | 1 | Carrier-synchronous sample clock |

## Verification
A wrong slope or a wrong direction state shows on `carrier` within one or two clocks of release, because the value ramps in exact quarter steps. A missed clamp shows as a carrier value outside ±peak, or as a `samp_clk` edge that falls on a value other than the extreme. A wrong comparison shows on `pwm_out` one clock after the tie or crossing, and a run with a zero sine crosses the carrier exactly at zero.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int DEF_FRAC_W = 24;
    localparam int DEF_INT_W  = 4;

    typedef enum logic {
        RAMP_UP = 1'b0,
        RAMP_DN = 1'b1
    } ramp_dir_t;

    typedef struct packed {
        ramp_dir_t dir;
        logic      samp;
    } ramp_flags_t;

endpackage

// File: rtl/spwm_slope.sv
module spwm_slope
    import spwm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int INT_W  = DEF_INT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [FRAC_W-1:0]             inc_i,
    input  logic [INT_W+FRAC_W-2:0]       peak_i,
    output logic [INT_W+FRAC_W-2:0]       slope_o
);
    localparam int PW = INT_W + FRAC_W - 1;
    localparam int MW = PW + FRAC_W;

    logic [MW-1:0] prod;

    assign prod = MW'(inc_i) * MW'(peak_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            slope_o <= '0;
        end else begin
            slope_o <= prod[FRAC_W +: PW];
        end
    end
endmodule

// File: rtl/spwm_ramp.sv
module spwm_ramp
    import spwm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int INT_W  = DEF_INT_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [INT_W+FRAC_W-2:0]          slope_i,
    input  logic [INT_W+FRAC_W-2:0]          peak_i,
    output logic signed [INT_W+FRAC_W-1:0]   tri_o,
    output logic                             samp_o
);
    localparam int TW = INT_W + FRAC_W;
    localparam int EW = TW + 1;

    ramp_flags_t         flg_q, flg_d;
    logic signed [TW-1:0] tri_d;
    logic signed [EW-1:0] pk_e, sl_e, cur_e, up_e, dn_e;

    assign pk_e  = $signed({2'b00, peak_i});
    assign sl_e  = $signed({2'b00, slope_i});
    assign cur_e = {tri_o[TW-1], tri_o};
    assign up_e  = cur_e + sl_e;
    assign dn_e  = cur_e - sl_e;

    always_comb begin
        flg_d = flg_q;
        tri_d = tri_o;
        if (flg_q.dir == RAMP_UP) begin
            if (up_e >= pk_e) begin
                tri_d      = pk_e[TW-1:0];
                flg_d.dir  = RAMP_DN;
                flg_d.samp = 1'b1;
            end else begin
                tri_d = up_e[TW-1:0];
            end
        end else begin
            if (dn_e <= -pk_e) begin
                tri_d      = (-pk_e);
                flg_d.dir  = RAMP_UP;
                flg_d.samp = 1'b0;
            end else begin
                tri_d = dn_e[TW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_o <= '0;
            flg_q <= '{dir: RAMP_UP, samp: 1'b0};
        end else begin
            tri_o <= tri_d;
            flg_q <= flg_d;
        end
    end

    assign samp_o = flg_q.samp;
endmodule

// File: rtl/spwm_cmp.sv
module spwm_cmp
    import spwm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int INT_W  = DEF_INT_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic signed [INT_W+FRAC_W-1:0] ref_i,
    input  logic signed [INT_W+FRAC_W-1:0] car_i,
    output logic                           gate_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o <= 1'b0;
        end else begin
            gate_o <= (ref_i > car_i);
        end
    end
endmodule

// File: rtl/spwm_carrier_gen.sv
module spwm_carrier_gen
    import spwm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int INT_W  = DEF_INT_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [FRAC_W-1:0]              freq_inc,
    input  logic [INT_W+FRAC_W-2:0]        peak_lvl,
    input  logic signed [INT_W+FRAC_W-1:0] sine_ref,
    output logic signed [INT_W+FRAC_W-1:0] carrier,
    output logic                           pwm_out,
    output logic                           samp_clk
);
    localparam int PW = INT_W + FRAC_W - 1;

    logic [PW-1:0] slope_q;

    spwm_slope #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_slope (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (freq_inc),
        .peak_i  (peak_lvl),
        .slope_o (slope_q)
    );

    spwm_ramp #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .slope_i (slope_q),
        .peak_i  (peak_lvl),
        .tri_o   (carrier),
        .samp_o  (samp_clk)
    );

    spwm_cmp #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .ref_i  (sine_ref),
        .car_i  (carrier),
        .gate_o (pwm_out)
    );
endmodule

// File: rtl/spwm_carrier_chk.sv
module spwm_carrier_chk
    import spwm_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int INT_W  = DEF_INT_W
) (
    input logic                           clk,
    input logic                           rst,
    input logic [INT_W+FRAC_W-2:0]        peak_lvl,
    input logic signed [INT_W+FRAC_W-1:0] sine_ref,
    input logic signed [INT_W+FRAC_W-1:0] carrier,
    input logic                           pwm_out,
    input logic                           samp_clk
);
    localparam int TW = INT_W + FRAC_W;

    // R2
    pos_peak_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(samp_clk) |-> (carrier == $signed({1'b0, $past(peak_lvl)})));

    // R3
    neg_peak_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(samp_clk) |-> (carrier == -$signed({1'b0, $past(peak_lvl)})));

    // R5
    pwm_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pwm_out == $past(sine_ref > carrier)));

    // R7
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (carrier == '0 && !pwm_out && !samp_clk));
endmodule

bind spwm_carrier_gen spwm_carrier_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .peak_lvl (peak_lvl),
    .sine_ref (sine_ref),
    .carrier  (carrier),
    .pwm_out  (pwm_out),
    .samp_clk (samp_clk)
);

// File: tb/spwm_carrier_gen_bench.sv
module spwm_carrier_gen_bench;
    localparam int FRAC_W = 24;
    localparam int INT_W  = 4;
    localparam int TW     = INT_W + FRAC_W;
    localparam longint ONE = 64'd1 << FRAC_W;
    localparam longint QTR = ONE / 4;
    localparam int NV = 20;

    localparam int EXP_TRI [NV] = '{0,1,2,3,4,3,2,1,0,-1,-2,-3,-4,-3,-2,-1,0,1,2,3};
    localparam bit EXP_SMP [NV] = '{0,0,0,0,1,1,1,1,1,1,1,1,0,0,0,0,0,0,0,0};
    localparam bit EXP_PWM [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,1,1,1,0,0,0};

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [FRAC_W-1:0]     freq_inc = '0;
    logic [TW-2:0]         peak_lvl = '0;
    logic signed [TW-1:0]  sine_ref = '0;
    logic signed [TW-1:0]  carrier;
    logic                  pwm_out;
    logic                  samp_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #10 clk = ~clk;

    spwm_carrier_gen #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_spwm_carrier_gen (
        .clk(clk), .rst(rst), .freq_inc(freq_inc), .peak_lvl(peak_lvl),
        .sine_ref(sine_ref), .carrier(carrier), .pwm_out(pwm_out), .samp_clk(samp_clk)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        longint mx, mn;
        int gap;
        bit bound_ok, pwm_ok;

        freq_inc = 24'(QTR);
        peak_lvl = (TW-1)'(ONE);
        sine_ref = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R7 reset state
        chk(carrier == 0 && !pwm_out && !samp_clk, "R7 reset outputs",
            {carrier, pwm_out, samp_clk}, 0);
        rst = 1'b0;

        // Table walk: slope 0.25, peak 1.0, sine 0 (R1 R2 R3 R5 R7)
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(carrier == EXP_TRI[i] * QTR, "R1 carrier step", carrier, EXP_TRI[i] * QTR);
            chk(samp_clk == EXP_SMP[i], "R2/R3 samp_clk", samp_clk, EXP_SMP[i]);
            chk(pwm_out == EXP_PWM[i], "R5 pwm compare", pwm_out, EXP_PWM[i]);
        end

        // R4 period between rising edges of samp_clk
        while (samp_clk) @(negedge clk);
        while (!samp_clk) @(negedge clk);
        gap = 0;
        while (samp_clk) begin @(negedge clk); gap++; end
        while (!samp_clk) begin @(negedge clk); gap++; end
        chk(gap == 16, "R4 carrier period", gap, 16);

        // R6 overmodulation: peak 0.5, sine +0.75
        peak_lvl = (TW-1)'(ONE / 2);
        sine_ref = TW'(3 * QTR);
        do_reset();
        mx = 0; mn = 0; bound_ok = 1'b1; pwm_ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (carrier > mx) mx = carrier;
            if (carrier < mn) mn = carrier;
            if (carrier > ONE / 2 || carrier < -(ONE / 2)) bound_ok = 1'b0;
            if (i > 0 && !pwm_out) pwm_ok = 1'b0;
        end
        chk(bound_ok, "R6 carrier bounded", mx, ONE / 2);
        chk(pwm_ok, "R6 pwm held high", pwm_out, 1);
        chk(mx == ONE / 2, "R2 reaches +peak", mx, ONE / 2);
        chk(mn == -(ONE / 2), "R3 reaches -peak", mn, -(ONE / 2));

        // R4 period unchanged with smaller peak
        while (samp_clk) @(negedge clk);
        while (!samp_clk) @(negedge clk);
        gap = 0;
        while (samp_clk) begin @(negedge clk); gap++; end
        while (!samp_clk) begin @(negedge clk); gap++; end
        chk(gap == 16, "R4 period independent of peak", gap, 16);

        // R6 negative overmodulation
        sine_ref = -TW'(3 * QTR);
        do_reset();
        pwm_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pwm_out) pwm_ok = 1'b0;
        end
        chk(pwm_ok, "R6 pwm held low", pwm_out, 0);

        // R1 slope scales with peak: peak 2.0, inc 0.25 -> slope 0.5
        peak_lvl = (TW-1)'(2 * ONE);
        freq_inc = 24'(QTR);
        sine_ref = '0;
        do_reset();
        @(posedge clk); @(negedge clk);
        chk(carrier == 0, "R7 first clock holds zero", carrier, 0);
        @(posedge clk); @(negedge clk);
        chk(carrier == ONE / 2, "R1 slope step 1", carrier, ONE / 2);
        @(posedge clk); @(negedge clk);
        chk(carrier == ONE, "R1 slope step 2", carrier, ONE);

        // R2/R3 clamp with non-dividing slope: peak 4.0, inc 0.1875 -> slope 0.75
        peak_lvl = (TW-1)'(4 * ONE);
        freq_inc = 24'(3 * (ONE / 16));
        do_reset();
        mx = 0; mn = 0; bound_ok = 1'b1;
        for (int i = 0; i < 120; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (carrier > mx) mx = carrier;
            if (carrier < mn) mn = carrier;
            if (carrier > 4 * ONE || carrier < -(4 * ONE)) bound_ok = 1'b0;
        end
        chk(bound_ok, "R2 R3 bounded non-dividing", mx, 4 * ONE);
        chk(mx == 4 * ONE, "R2 clamps to +peak", mx, 4 * ONE);
        chk(mn == -(4 * ONE), "R3 clamps to -peak", mn, -(4 * ONE));

        finish_run();
    end
endmodule